// File: doc/BRIEF.md
# Stepped-Duty Charge-Pump PWM Generator

This block drives the switching node of a switched-capacitor voltage inverter with a fixed-frequency square wave. A two-stage prescaler turns the system clock into a slow timer tick. The output waveform is made of two alternating intervals, high and low, and each interval's length in ticks comes from its own count. The two counts always add up to the period, so the frequency stays fixed while the duty cycle changes.

A one-cycle contrast-step pulse moves the duty cycle up by one fixed step. The high count gains the step and the low count loses it. Stepping from the top setting wraps round to the bottom setting; it does not saturate. A step is held until the next period boundary (the low-to-high edge), so no interval is ever cut short or stretched. Turning the block off forces the output low and halts the compare logic. Turning it on again always starts from the half-period setting.

Each edge of the waveform is placed by toggle-on-compare against a free-running timer. The timer wraps modulo two to the power of its width. The next compare point is the previous compare point plus the length of the level just entered, so interval lengths stay exact when the timer wraps.

Top module: `cpwm_gen`

## Requirements
- R1: The timer tick fires once every PRE_A*PRE_B clocks. With reset released before clock edge 1, the tick is consumed on edges whose number is a multiple of PRE_A*PRE_B.
- R2: During reset and on every clock edge at which `enable_i` is low, `pwm_o` is low and `hi_count_o` equals PERIOD/2.
- R3: With `enable_i` high and the block idle, the first tick edge starts a period. `pwm_o` goes high and both counts hold PERIOD/2.
- R4: While running, a high level lasts exactly (high count)×PRE_A×PRE_B clocks and a low level lasts (low count)×PRE_A×PRE_B clocks. `pwm_o` changes only on tick edges.
- R5: The high count plus the low count always equals PERIOD, so every full period is PERIOD×PRE_A×PRE_B clocks long.
- R6: A step pulse seen on an edge while running is held and applied at the next low-to-high boundary: the high count rises by STEP and the low count falls by STEP. Any number of steps within one period has the effect of one.
- R7: A step applied while the high count equals HI_MAX loads a high count of PERIOD−HI_MAX and a low count of HI_MAX. With the defaults, repeated steps give 125, 137, 149, 161, 173, 185, 197, 53, 65, …
- R8: `hi_count_o` shows the high count in effect. It changes on the same edge as the rising output edge that starts the new period.
- R9: Interval lengths stay exact when the timer wraps modulo 2^TIMER_W.
- R10: A step pulse seen while disabled, or while enabled but not yet started, is discarded. The first period after enabling still has a high count of PERIOD/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the generator when high; hold the output low when low |
| step_i | input | 1 | One-cycle request to advance the duty cycle by one step |
| pwm_o | output | 1 | Square wave to the charge-pump switches |
| hi_count_o | output | 8 | High-interval length in ticks currently in effect |

## Verification
The hardest state to reach from the ports is a compare point that lies past the timer's wrap. At the default width it takes 65,536 ticks to get there. The bench therefore builds the block with a 9-bit timer and a divide-by-4 prescale, so the timer wraps every few periods. Across dozens of periods, compare points fall on both sides of the wrap, and every interval is checked against a behavioural model on every clock. Steps are also placed deliberately: mid-high, mid-low, twice in one period, at the 197 ceiling, and while disabled. This exercises both the deferral to the period boundary and the wrap from 80% to 20%.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int unsigned DUTY_W = 8;
    typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale #(
    parameter int unsigned PRE_A = 4,
    parameter int unsigned PRE_B = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned AW = (PRE_A > 1) ? $clog2(PRE_A) : 1;
    localparam int unsigned BW = (PRE_B > 1) ? $clog2(PRE_B) : 1;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] b;
    } pre_t;

    pre_t st_q, st_d;
    logic a_last, b_last;

    always_comb begin
        st_d   = st_q;
        a_last = (st_q.a == AW'(PRE_A - 1));
        b_last = (st_q.b == BW'(PRE_B - 1));
        if (a_last) begin
            st_d.a = '0;
            if (b_last) st_d.b = '0;
            else        st_d.b = st_q.b + 1'b1;
        end else begin
            st_d.a = st_q.a + 1'b1;
        end
        tick_o = a_last && b_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (PRE_A * PRE_B > 1) begin : g_gap
            // R1: ticks never come on consecutive edges
            p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/cpwm_duty.sv
module cpwm_duty
    import cpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 250,
    parameter int unsigned STEP   = 12,
    parameter int unsigned HI_MAX = 197
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_i,
    input  logic  step_i,
    input  logic  apply_i,
    output duty_t hi_o,
    output duty_t lo_o,
    output duty_t hi_nx_o
);
    localparam duty_t HALF_C = duty_t'(PERIOD / 2);
    localparam duty_t STEP_C = duty_t'(STEP);
    localparam duty_t HMAX_C = duty_t'(HI_MAX);
    localparam duty_t HMIN_C = duty_t'(PERIOD - HI_MAX);

    typedef struct packed {
        duty_t hi;
        duty_t lo;
        logic  pend;
    } duty_st_t;

    duty_st_t st_q, st_d;
    logic  adv;
    duty_t nx_hi, nx_lo;

    always_comb begin
        st_d = st_q;
        adv  = st_q.pend | step_i;
        if (!adv) begin
            nx_hi = st_q.hi;
            nx_lo = st_q.lo;
        end else if (st_q.hi == HMAX_C) begin
            nx_hi = HMIN_C;
            nx_lo = HMAX_C;
        end else begin
            nx_hi = st_q.hi + STEP_C;
            nx_lo = st_q.lo - STEP_C;
        end

        if (clear_i) begin
            st_d.hi   = HALF_C;
            st_d.lo   = HALF_C;
            st_d.pend = 1'b0;
        end else if (apply_i) begin
            st_d.hi   = nx_hi;
            st_d.lo   = nx_lo;
            st_d.pend = 1'b0;
        end else begin
            st_d.pend = adv;
        end

        hi_nx_o = apply_i ? nx_hi : st_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hi   <= HALF_C;
            st_q.lo   <= HALF_C;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o = st_q.hi;
    assign lo_o = st_q.lo;

    // R5: the two interval counts always fill one period
    p_sum_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, hi_o} + {1'b0, lo_o}) == 9'(PERIOD));
    // R7: the high count stays inside the legal band
    p_hi_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_o >= HMIN_C) && (hi_o <= HMAX_C || hi_o == HALF_C));
    // R7: a step taken at the ceiling lands on the floor
    p_wrap_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && apply_i && (st_q.pend || step_i) && hi_o == HMAX_C) |=> hi_o == HMIN_C);
    // R6: a step taken below the ceiling adds one step
    p_step_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && apply_i && (st_q.pend || step_i) && hi_o != HMAX_C) |=> hi_o == $past(hi_o) + STEP_C);
    // R6: without an apply, the high count holds while running
    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !apply_i) |=> $stable(hi_o));
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare
    import cpwm_pkg::*;
#(
    parameter int unsigned TIMER_W = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  tick_i,
    input  duty_t hi_nx_i,
    input  duty_t lo_i,
    output logic  pwm_o,
    output logic  run_o,
    output logic  apply_o
);
    typedef logic [TIMER_W-1:0] tmr_t;

    typedef struct packed {
        tmr_t timer;
        tmr_t cmp;
        logic run;
        logic pwm;
    } cmp_st_t;

    cmp_st_t st_q, st_d;
    tmr_t tnext;
    logic hit;

    always_comb begin
        st_d    = st_q;
        apply_o = 1'b0;
        tnext   = st_q.timer + 1'b1;
        hit     = tick_i && (tnext == st_q.cmp);
        if (tick_i) st_d.timer = tnext;

        if (!en_i) begin
            st_d.run = 1'b0;
            st_d.pwm = 1'b0;
        end else if (!st_q.run) begin
            if (tick_i) begin
                st_d.run = 1'b1;
                st_d.pwm = 1'b1;
                st_d.cmp = tnext + tmr_t'(hi_nx_i);
            end
        end else if (hit) begin
            st_d.pwm = ~st_q.pwm;
            if (st_q.pwm) begin
                st_d.cmp = st_q.cmp + tmr_t'(lo_i);
            end else begin
                apply_o  = 1'b1;
                st_d.cmp = st_q.cmp + tmr_t'(hi_nx_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;
    assign run_o = st_q.run;

    // R2: a disabled edge leaves the output low
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);
    // R3: an idle, enabled tick starts a high interval
    p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !run_o && tick_i) |=> (pwm_o && run_o));
    // R4: the output only moves on a tick edge or when switched off
    p_toggle_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && run_o && !tick_i) |=> $stable(pwm_o));
    // R6: boundaries into high happen only from a low level
    p_apply_from_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> $rose(pwm_o));
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
    import cpwm_pkg::*;
#(
    parameter int unsigned PRE_A   = 4,
    parameter int unsigned PRE_B   = 8,
    parameter int unsigned TIMER_W = 16,
    parameter int unsigned PERIOD  = 250,
    parameter int unsigned STEP    = 12,
    parameter int unsigned HI_MAX  = 197
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable_i,
    input  logic        step_i,
    output logic        pwm_o,
    output logic [7:0]  hi_count_o
);
    logic  tick, run, apply, clear;
    duty_t hi, lo, hi_nx;

    cpwm_prescale #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    assign clear = !(enable_i && run);

    cpwm_duty #(.PERIOD(PERIOD), .STEP(STEP), .HI_MAX(HI_MAX)) u_duty (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .step_i  (step_i),
        .apply_i (apply),
        .hi_o    (hi),
        .lo_o    (lo),
        .hi_nx_o (hi_nx)
    );

    cpwm_compare #(.TIMER_W(TIMER_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable_i),
        .tick_i  (tick),
        .hi_nx_i (hi_nx),
        .lo_i    (lo),
        .pwm_o   (pwm_o),
        .run_o   (run),
        .apply_o (apply)
    );

    assign hi_count_o = hi;

    // R8: the shown high count changes only together with a rising output or a switch-off
    p_count_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && run && !apply) |=> $stable(hi_count_o));
endmodule

// File: tb/test_cpwm_gen.sv
module test_cpwm_gen;
    localparam int PA = 2;
    localparam int PB = 2;
    localparam int DIV = PA * PB;
    localparam int PER = 250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_r = 1'b0;
    logic step_r = 1'b0;
    logic pwm_o;
    logic [7:0] hi_count_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    cpwm_gen #(.PRE_A(PA), .PRE_B(PB), .TIMER_W(9), .PERIOD(PER), .STEP(12), .HI_MAX(197)) i_cpwm_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (en_r),
        .step_i     (step_r),
        .pwm_o      (pwm_o),
        .hi_count_o (hi_count_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: edge count, level, ticks left in level, counts, held step
    int e, mrem, mhi, mlo;
    bit mrun, mpwm, mpend, tk, adv;
    always @(posedge clk) begin
        if (!rst_n) begin
            e = 0; mrun = 0; mpwm = 0; mhi = PER / 2; mlo = PER / 2; mpend = 0; mrem = 0;
        end else begin
            e++;
            tk = (e % DIV == 0);
            if (!en_r) begin
                mrun = 0; mpwm = 0; mhi = PER / 2; mlo = PER / 2; mpend = 0;
            end else if (!mrun) begin
                if (tk) begin mrun = 1; mpwm = 1; mrem = mhi; end
            end else begin
                adv = mpend | step_r;
                if (tk && mrem == 1) begin
                    if (mpwm) begin
                        mpwm = 0; mrem = mlo; mpend = adv;
                    end else begin
                        if (adv) begin
                            if (mhi == 197) begin mhi = 53; mlo = 197; end
                            else begin mhi += 12; mlo -= 12; end
                        end
                        mpend = 0; mpwm = 1; mrem = mhi;
                    end
                end else begin
                    if (tk) mrem--;
                    mpend = adv;
                end
            end
        end
    end

    // R4 R9: per-clock comparison with the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(pwm_o === mpwm, "R4", "pwm level", int'(pwm_o), int'(mpwm));
            chk(int'(hi_count_o) == mhi, "R8", "high count", int'(hi_count_o), mhi);
        end
    end

    // R5: each full period measured at the port is PER*DIV clocks
    bit prev_p = 0, started = 0;
    int pcnt = 0;
    always @(negedge clk) begin
        if (!rst_n || !en_r) begin
            started = 0; pcnt = 0; prev_p = 0;
        end else begin
            if (pwm_o && !prev_p) begin
                if (started) chk(pcnt == PER * DIV, "R5", "period clocks", pcnt, PER * DIV);
                started = 1; pcnt = 0;
            end
            pcnt++;
            prev_p = pwm_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            failures++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_rise();
        logic p;
        p = pwm_o;
        forever begin
            @(negedge clk);
            if (pwm_o && !p) break;
            p = pwm_o;
        end
    endtask

    task automatic pulse_step();
        @(negedge clk) step_r = 1'b1;
        @(negedge clk) step_r = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int lat, expv;
        // reset state: R2
        wait_clk(3);
        chk(pwm_o == 1'b0, "R2", "pwm in reset", int'(pwm_o), 0);
        chk(hi_count_o == 8'd125, "R2", "count in reset", int'(hi_count_o), 125);
        rst_n = 1'b1;
        wait_clk(40);
        chk(pwm_o == 1'b0, "R2", "pwm while disabled", int'(pwm_o), 0);

        // R10: step while disabled is dropped
        pulse_step();
        // R3 R1: start latency bounded by one tick interval
        @(negedge clk) en_r = 1'b1;
        lat = 0;
        while (!pwm_o && lat < 4 * DIV) begin @(negedge clk); lat++; end
        chk(lat <= DIV, "R3", "start latency", lat, DIV);
        chk(hi_count_o == 8'd125, "R10", "count after enable", int'(hi_count_o), 125);
        wait_rise();
        wait_rise();

        // R6 R7: stepped sequence with wrap from ceiling to floor
        expv = 125;
        for (int k = 0; k < 14; k++) begin
            wait_clk(30 + 37 * k);
            pulse_step();
            wait_rise();
            expv = (expv == 197) ? 53 : expv + 12;
            chk(int'(hi_count_o) == expv, "R7", "stepped high count", int'(hi_count_o), expv);
        end

        // R6: two steps in one period count as one; step held over mid-period
        wait_rise();
        expv = int'(hi_count_o);
        wait_clk(50);
        pulse_step();
        wait_clk(DIV * 140);
        pulse_step();
        chk(int'(hi_count_o) == expv, "R6", "count held until boundary", int'(hi_count_o), expv);
        wait_rise();
        expv = (expv == 197) ? 53 : expv + 12;
        chk(int'(hi_count_o) == expv, "R6", "coalesced steps", int'(hi_count_o), expv);
        wait_rise();
        chk(int'(hi_count_o) == expv, "R6", "no extra step", int'(hi_count_o), expv);

        // R2: disable mid-period forces low and resets count
        wait_clk(DIV * 30);
        @(negedge clk) en_r = 1'b0;
        @(negedge clk);
        chk(pwm_o == 1'b0, "R2", "pwm after disable", int'(pwm_o), 0);
        chk(hi_count_o == 8'd125, "R2", "count after disable", int'(hi_count_o), 125);
        pulse_step();
        wait_clk(25);
        chk(pwm_o == 1'b0, "R2", "pwm stays low", int'(pwm_o), 0);

        // R10 R9: restart at half setting, run many timer wraps
        @(negedge clk) en_r = 1'b1;
        pulse_step();
        wait_rise();
        chk(hi_count_o == 8'd125, "R10", "restart count", int'(hi_count_o), 125);
        for (int k = 0; k < 6; k++) begin
            wait_clk(11 + 173 * k);
            if (k % 2 == 0) pulse_step();
            wait_rise();
        end
        wait_rise();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule